// File: doc/BRIEF.md
# Multi-Source Reset Conditioner

This block turns three kinds of reset request into registered, active-low resets that are safe to use inside one local clock domain. A board-level asynchronous reset enters a chain of flops clocked by the local clock. The reset it produces takes effect the moment the input drops. It is removed only after a set number of local rising edges, so that the release always lines up with the clock.

A second request is the AND of two qualifier inputs. Because that AND gate can glitch, the request is captured by a flop before it becomes a reset. The cost is one extra cycle of latency. A third request arrives from a flop in another clock domain. It enters a chain of flops, all clocked on the rising edge of the local clock. No logic sits ahead of the first flop of that chain.

Both derived resets are held active while the synchronized board reset is active. No flop in the block has more than one asynchronous control input.

Top module: `rst_conditioner`

## Requirements
- R1: While ext_rst_n is 0, sync_rst_n, gated_rst_n and xdom_rst_n are all 0 (0 means reset active). They drop at once, without waiting for a clock edge, and the qualifier and foreign inputs have no effect during this time.
- R2: After ext_rst_n returns to 1 between two edges, sync_rst_n stays 0 through the first STAGES-1 rising edges and becomes 1 on the STAGES-th. It then stays 1 as long as ext_rst_n stays 1.
- R3: While sync_rst_n is 1, gated_rst_n after a rising edge equals NOT(qual_a AND qual_b) as sampled at that edge. A reset request means both qualifiers are 1, and it shows on gated_rst_n exactly one edge after it is sampled.
- R4: Pulses on qual_a or qual_b that begin and end between two rising edges do not change gated_rst_n, whichever level that output holds.
- R5: With sync_rst_n at 1, the level that foreign_rst_n holds at a rising edge appears on xdom_rst_n after the STAGES-th rising edge, counting the edge that sampled it. This holds for single-cycle pulses as well as for long levels.
- R6: While sync_rst_n is 0, gated_rst_n and xdom_rst_n stay 0. The gated flop first follows its request on the edge after the edge at which sync_rst_n becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; all flops use its rising edge |
| ext_rst_n | input | 1 | Asynchronous board reset, active low |
| qual_a | input | 1 | First reset qualifier, fed through combinational logic |
| qual_b | input | 1 | Second reset qualifier; a request is qual_a AND qual_b |
| foreign_rst_n | input | 1 | Active-low reset taken from a flop in another clock domain |
| sync_rst_n | output | 1 | Board reset, asserted at once and released in step with clk |
| gated_rst_n | output | 1 | Registered, glitch-free copy of the qualified request |
| xdom_rst_n | output | 1 | Foreign reset after the local synchronizer chain |

## Verification
The bench builds the block with STAGES set to 3 rather than the default of 2. This makes the release count and the cross-domain delay longer than the minimum, so a stage that is dropped or added shows up as a wrong edge count. The qualifier input is swept over every pair of successive qualifier codes. The foreign input is driven with a pattern that mixes single-cycle pulses and long levels, and each output value is predicted from a delay line of STAGES edges. Short pulses are placed on the qualifiers in the middle of a cycle, while the gated output is held at 1 and while it is held at 0.

// File: rtl/rst_conditioner.sv
module rst_conditioner #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic qual_a,
  input  logic qual_b,
  input  logic foreign_rst_n,
  output logic sync_rst_n,
  output logic gated_rst_n,
  output logic xdom_rst_n
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] ext_sh;
  logic [N-1:0] xd_sh;
  logic         gq;
  logic         req;

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n) ext_sh <= '0;
    else            ext_sh <= {ext_sh[N-2:0], 1'b1};

  assign sync_rst_n = ext_sh[N-1];
  assign req        = qual_a & qual_b;

  always_ff @(posedge clk or negedge sync_rst_n)
    if (!sync_rst_n) gq <= 1'b0;
    else             gq <= ~req;

  assign gated_rst_n = gq;

  always_ff @(posedge clk or negedge sync_rst_n)
    if (!sync_rst_n) xd_sh <= '0;
    else             xd_sh <= {xd_sh[N-2:0], foreign_rst_n};

  assign xdom_rst_n = xd_sh[N-1];
endmodule

// File: rtl/rst_conditioner_chk.sv
module rst_conditioner_chk #(
  parameter int STAGES = 2
) (
  input logic clk,
  input logic ext_rst_n,
  input logic qual_a,
  input logic qual_b,
  input logic foreign_rst_n,
  input logic sync_rst_n,
  input logic gated_rst_n,
  input logic xdom_rst_n
);
  localparam int N  = (STAGES < 2) ? 2 : STAGES;
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] run;
  logic          fp;

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n) begin
      run <= '0;
      fp  <= 1'b0;
    end else begin
      fp <= foreign_rst_n;
      if (!sync_rst_n || foreign_rst_n != fp) run <= '0;
      else if (run < CW'(N)) run <= run + 1'b1;
    end

  // R2
  sync_hold_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    sync_rst_n |=> sync_rst_n);

  // R3
  gated_follow_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $past(sync_rst_n) |-> gated_rst_n == !($past(qual_a) && $past(qual_b)));

  // R6
  held_low_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !sync_rst_n |-> (!gated_rst_n && !xdom_rst_n));

  // R5
  xdom_copy_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (run >= CW'(N) && foreign_rst_n == fp) |-> xdom_rst_n == foreign_rst_n);
endmodule

bind rst_conditioner rst_conditioner_chk #(.STAGES(STAGES)) chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .qual_a(qual_a), .qual_b(qual_b),
  .foreign_rst_n(foreign_rst_n), .sync_rst_n(sync_rst_n),
  .gated_rst_n(gated_rst_n), .xdom_rst_n(xdom_rst_n));

// File: tb/rst_conditioner_test.sv
`timescale 1ns/1ps
module rst_conditioner_test;
  localparam int N = 3;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0, qual_a = 1'b0, qual_b = 1'b0, foreign_rst_n = 1'b0;
  logic sync_rst_n, gated_rst_n, xdom_rst_n;
  int   n_chk = 0, n_bad = 0;
  logic [15:0] hist;

  always #4 clk = ~clk;

  rst_conditioner #(.STAGES(N)) uut (
    .clk(clk), .ext_rst_n(ext_rst_n), .qual_a(qual_a), .qual_b(qual_b),
    .foreign_rst_n(foreign_rst_n), .sync_rst_n(sync_rst_n),
    .gated_rst_n(gated_rst_n), .xdom_rst_n(xdom_rst_n));

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic done;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    done();
  end

  initial begin
    #1;
    chk("R1 sync", sync_rst_n, 1'b0);
    chk("R1 gated", gated_rst_n, 1'b0);
    chk("R1 xdom", xdom_rst_n, 1'b0);
    foreign_rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R1 sync held", sync_rst_n, 1'b0);
      chk("R1 gated held", gated_rst_n, 1'b0);
      chk("R1 xdom held", xdom_rst_n, 1'b0);
    end

    // release: request inactive, foreign high
    ext_rst_n = 1'b1;
    for (int k = 1; k <= 2 * N; k++) begin
      tick();
      chk("R2 release", sync_rst_n, (k >= N) ? 1'b1 : 1'b0);
      chk("R6 gated", gated_rst_n, (k >= N + 1) ? 1'b1 : 1'b0);
      chk("R6 xdom", xdom_rst_n, (k >= 2 * N) ? 1'b1 : 1'b0);
    end

    // R3 sweep over every pair of successive qualifier codes
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        qual_a = p[0]; qual_b = p[1];
        tick();
        qual_a = c[0]; qual_b = c[1];
        chk("R3 latency", gated_rst_n, ~(p[0] & p[1]));
        tick();
        chk("R3 follow", gated_rst_n, ~(c[0] & c[1]));
        chk("R2 stays", sync_rst_n, 1'b1);
      end
    end

    // R4 glitches while output high
    qual_a = 1'b1; qual_b = 1'b0;
    tick();
    chk("R4 setup", gated_rst_n, 1'b1);
    for (int i = 0; i < 4; i++) begin
      #2 qual_b = 1'b1;
      #1 qual_b = 1'b0;
      chk("R4 mid", gated_rst_n, 1'b1);
      tick();
      chk("R4 high", gated_rst_n, 1'b1);
    end
    qual_a = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1 begin qual_a = 1'b1; qual_b = 1'b1; end
      #2 begin qual_a = 1'b0; qual_b = 1'b0; end
      tick();
      chk("R4 both", gated_rst_n, 1'b1);
    end
    // R4 glitches while output low
    qual_a = 1'b1; qual_b = 1'b1;
    tick();
    tick();
    chk("R4 setup low", gated_rst_n, 1'b0);
    for (int i = 0; i < 4; i++) begin
      #2 qual_a = 1'b0;
      #1 qual_a = 1'b1;
      tick();
      chk("R4 low", gated_rst_n, 1'b0);
    end
    qual_a = 1'b0; qual_b = 1'b0;
    tick();

    // R5 delay line sweep
    hist = '1;
    for (int i = 0; i < 48; i++) begin
      foreign_rst_n = !((i % 9) == 2 || (i >= 20 && i < 24) || i == 30 || i == 31 || i == 40);
      hist = {hist[14:0], foreign_rst_n};
      tick();
      chk("R5 delay", xdom_rst_n, hist[N-1]);
    end
    foreign_rst_n = 1'b1;
    for (int i = 0; i < N; i++) tick();
    chk("R5 settle", xdom_rst_n, 1'b1);

    // R1 mid-operation assertion
    ext_rst_n = 1'b0;
    #1;
    chk("R1 async sync", sync_rst_n, 1'b0);
    chk("R1 async gated", gated_rst_n, 1'b0);
    chk("R1 async xdom", xdom_rst_n, 1'b0);
    for (int i = 0; i < 2; i++) begin
      tick();
      chk("R1 ignore gated", gated_rst_n, 1'b0);
      chk("R1 ignore xdom", xdom_rst_n, 1'b0);
    end

    // second release with a pending request
    qual_a = 1'b1; qual_b = 1'b1;
    ext_rst_n = 1'b1;
    for (int k = 1; k <= N + 1; k++) begin
      tick();
      chk("R2 re-release", sync_rst_n, (k >= N) ? 1'b1 : 1'b0);
      chk("R6 gated req", gated_rst_n, 1'b0);
    end
    qual_b = 1'b0;
    tick();
    chk("R3 after release", gated_rst_n, 1'b1);

    done();
  end
endmodule